// File: doc/BRIEF.md
# Critical Section Request Buffer

This block sits between a population of small in-order cores and one large core that runs contended critical sections on their behalf. A small core that reaches a critical section sends a call carrying the lock address, the program counter where the section begins, its stack pointer and its own core number. The call then stalls that core. The buffer keeps such calls in arrival order and hands them, one at a time, to the large core. When the large core signals that it has left the section, the buffer sends a completion response addressed to the core that made the call.

Shipping every section to the large core can be harmful. Sections that guard different locks could have run in parallel on their own cores, but the single large core serialises them. The buffer watches for this with a table of small saturating counters, indexed by the low bits of the lock address. A counter grows when a call queues behind a call for some other lock. It shrinks when its lock is dispatched with only same-lock calls still behind it. Once a counter reaches a threshold, further calls for that index are not queued. They are answered straight away with a response that tells the caller to run the section on its own core.

Top module: `cs_request_buffer`

## Requirements
- R1: After reset the queue is empty, every counter is zero, no section is in flight, `req_ready` is 1 and `disp_valid`, `done_valid` and `local_valid` are 0.
- R2: `req_ready` is 1 exactly when fewer than DEPTH calls are queued and no run-locally response is pending. A call is taken at a rising edge where `req_valid` and `req_ready` are both 1.
- R3: The dispatch port always presents the oldest queued call, with its lock, PC, stack pointer and core number unchanged. Calls leave in the order they were taken.
- R4: `disp_valid` is 1 only when the queue is non-empty and no section is in flight. A section is in flight from its dispatch handshake (`disp_valid` and `disp_ready`) until its completion handshake.
- R5: `ret_valid` at an edge while a section executes raises `done_valid` in the next cycle, with `done_core` equal to the dispatched call's core number. Both are held until `done_ready` is 1 at an edge. `ret_valid` at any other time has no effect.
- R6: The counter index of a call is `lock[IDX_W-1:0]`. When a call is taken while the queue holds at least one call whose full lock address differs from it, the counter at the new call's index increments. It saturates at 2^CNT_W-1.
- R7: At a dispatch handshake, if no queued call other than the head has a lock address different from the head's, the counter at the head's index decrements. It saturates at 0. If an increment and a decrement hit the same counter at the same edge, the counter is unchanged.
- R8: A call taken while its counter (value before the edge) is at least THRESH is not queued. From the next cycle `local_valid` is 1 with `local_core` set to the caller's core number, held until `local_ready` is 1 at an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A small core offers a call |
| req_ready | output | 1 | The buffer can take a call |
| req_lock | input | LOCK_W | Lock address of the call |
| req_pc | input | PC_W | Start address of the section |
| req_sp | input | SP_W | Caller's stack pointer |
| req_core | input | CORE_W | Caller's core number |
| disp_valid | output | 1 | A call is offered to the large core |
| disp_ready | input | 1 | The large core takes the offered call |
| disp_lock | output | LOCK_W | Lock address of the offered call |
| disp_pc | output | PC_W | Section start address of the offered call |
| disp_sp | output | SP_W | Stack pointer of the offered call |
| disp_core | output | CORE_W | Core number of the offered call |
| ret_valid | input | 1 | The large core has released the lock and returned |
| done_valid | output | 1 | Completion response pending |
| done_ready | input | 1 | The completion response is taken |
| done_core | output | CORE_W | Core the completion is addressed to |
| local_valid | output | 1 | Run-locally response pending |
| local_ready | input | 1 | The run-locally response is taken |
| local_core | output | CORE_W | Core the run-locally response is addressed to |

## Verification
Two pairs of events can land on the same edge. A call can be taken while the head is dispatched, which makes the queue push and pop together. A counter can also be asked to increment, for the arriving call, and to decrement, for the departing head, at the same index. The bench provokes both with long random streams that use aliased lock addresses: different addresses that share a counter index. It holds `disp_ready` high often enough that arrivals and dispatches overlap. A behavioural model predicts each call's queue-or-run-locally decision from its own counters, and its prediction is compared with the ports in every cycle. So a wrong tie rule, or a lost push or pop, shows up as a wrong response on a later call.

// File: rtl/csrb_pkg.sv
package csrb_pkg;
    // Life cycle of the one section the large core may hold.
    typedef enum logic [1:0] {
        LC_IDLE = 2'd0,
        LC_EXEC = 2'd1,
        LC_RESP = 2'd2
    } lc_state_e;
endpackage

// File: rtl/csrb_fifo.sv
module csrb_fifo #(
    parameter int DEPTH  = 8,
    parameter int LOCK_W = 32,
    parameter int PC_W   = 32,
    parameter int SP_W   = 32,
    parameter int CORE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LOCK_W-1:0] in_lock,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [SP_W-1:0]   in_sp,
    input  logic [CORE_W-1:0] in_core,
    input  logic              pop,
    output logic [LOCK_W-1:0] hd_lock,
    output logic [PC_W-1:0]   hd_pc,
    output logic [SP_W-1:0]   hd_sp,
    output logic [CORE_W-1:0] hd_core,
    output logic              full,
    output logic              empty,
    output logic              in_conflict,
    output logic              head_alone
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][LOCK_W-1:0] lock;
        logic [DEPTH-1:0][PC_W-1:0]   pc;
        logic [DEPTH-1:0][SP_W-1:0]   sp;
        logic [DEPTH-1:0][CORE_W-1:0] core;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W:0]               cnt;
    } fifo_s;

    fifo_s fifo_q, fifo_d;

    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] diff_in;
    logic [DEPTH-1:0] diff_head;

    // Per-slot occupancy and lock comparisons against the newcomer and the head.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [PTR_W-1:0] age;
        assign age          = PTR_W'(g) - fifo_q.rd;
        assign occ[g]       = ({1'b0, age} < fifo_q.cnt);
        assign diff_in[g]   = occ[g] && (fifo_q.lock[g] != in_lock);
        assign diff_head[g] = occ[g] && (PTR_W'(g) != fifo_q.rd)
                              && (fifo_q.lock[g] != fifo_q.lock[fifo_q.rd]);
    end

    assign in_conflict = |diff_in;
    assign head_alone  = ~|diff_head;
    assign full        = (fifo_q.cnt == (PTR_W+1)'(DEPTH));
    assign empty       = (fifo_q.cnt == '0);
    assign hd_lock     = fifo_q.lock[fifo_q.rd];
    assign hd_pc       = fifo_q.pc[fifo_q.rd];
    assign hd_sp       = fifo_q.sp[fifo_q.rd];
    assign hd_core     = fifo_q.core[fifo_q.rd];

    always_comb begin
        fifo_d = fifo_q;
        if (push) begin
            fifo_d.lock[fifo_q.wr] = in_lock;
            fifo_d.pc[fifo_q.wr]   = in_pc;
            fifo_d.sp[fifo_q.wr]   = in_sp;
            fifo_d.core[fifo_q.wr] = in_core;
            fifo_d.wr              = fifo_q.wr + 1'b1;
        end
        if (pop) begin
            fifo_d.rd = fifo_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R4
endmodule

// File: rtl/csrb_sat_table.sv
module csrb_sat_table #(
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 3,
    parameter int THRESH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic             dec_en,
    input  logic [IDX_W-1:0] dec_idx,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_hot
);
    localparam int N_CNT = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [N_CNT-1:0][CNT_W-1:0] c;
    } sat_s;

    sat_s sat_q, sat_d;

    logic [N_CNT-1:0] up;
    logic [N_CNT-1:0] dn;

    for (genvar g = 0; g < N_CNT; g++) begin : g_ctr
        assign up[g] = inc_en && (inc_idx == IDX_W'(g));
        assign dn[g] = dec_en && (dec_idx == IDX_W'(g));
    end

    always_comb begin
        sat_d = sat_q;
        for (int i = 0; i < N_CNT; i++) begin
            if (up[i] && !dn[i] && (sat_q.c[i] != CNT_MAX)) begin
                sat_d.c[i] = sat_q.c[i] + 1'b1;
            end else if (dn[i] && !up[i] && (sat_q.c[i] != '0)) begin
                sat_d.c[i] = sat_q.c[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sat_q <= '0;
        end else begin
            sat_q <= sat_d;
        end
    end

    assign look_hot = ({1'b0, sat_q.c[look_idx]} >= (CNT_W+1)'(THRESH));
endmodule

// File: rtl/cs_request_buffer.sv
module cs_request_buffer
    import csrb_pkg::*;
#(
    parameter int CORE_W = 5,
    parameter int LOCK_W = 32,
    parameter int PC_W   = 32,
    parameter int SP_W   = 32,
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 3,
    parameter int THRESH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LOCK_W-1:0] req_lock,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [SP_W-1:0]   req_sp,
    input  logic [CORE_W-1:0] req_core,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [LOCK_W-1:0] disp_lock,
    output logic [PC_W-1:0]   disp_pc,
    output logic [SP_W-1:0]   disp_sp,
    output logic [CORE_W-1:0] disp_core,
    input  logic              ret_valid,
    output logic              done_valid,
    input  logic              done_ready,
    output logic [CORE_W-1:0] done_core,
    output logic              local_valid,
    input  logic              local_ready,
    output logic [CORE_W-1:0] local_core
);
    typedef struct packed {
        lc_state_e         st;
        logic [CORE_W-1:0] owner;
        logic              loc_v;
        logic [CORE_W-1:0] loc_core;
    } ctl_s;

    ctl_s ctl_q, ctl_d;

    logic full, empty, in_conflict, head_alone, hot;
    logic accept, push, pop;

    assign req_ready = !full && !ctl_q.loc_v;
    assign accept    = req_valid && req_ready;
    assign push      = accept && !hot;
    assign disp_valid = (ctl_q.st == LC_IDLE) && !empty;
    assign pop       = disp_valid && disp_ready;

    csrb_fifo #(
        .DEPTH (DEPTH),
        .LOCK_W(LOCK_W),
        .PC_W  (PC_W),
        .SP_W  (SP_W),
        .CORE_W(CORE_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .in_lock    (req_lock),
        .in_pc      (req_pc),
        .in_sp      (req_sp),
        .in_core    (req_core),
        .pop        (pop),
        .hd_lock    (disp_lock),
        .hd_pc      (disp_pc),
        .hd_sp      (disp_sp),
        .hd_core    (disp_core),
        .full       (full),
        .empty      (empty),
        .in_conflict(in_conflict),
        .head_alone (head_alone)
    );

    csrb_sat_table #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W),
        .THRESH(THRESH)
    ) u_serial_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (accept && in_conflict),
        .inc_idx (req_lock[IDX_W-1:0]),
        .dec_en  (pop && head_alone),
        .dec_idx (disp_lock[IDX_W-1:0]),
        .look_idx(req_lock[IDX_W-1:0]),
        .look_hot(hot)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            LC_IDLE: if (pop) begin
                ctl_d.st    = LC_EXEC;
                ctl_d.owner = disp_core;
            end
            LC_EXEC: if (ret_valid) ctl_d.st = LC_RESP;
            LC_RESP: if (done_ready) ctl_d.st = LC_IDLE;
            default: ctl_d.st = LC_IDLE;
        endcase
        if (ctl_q.loc_v && local_ready) begin
            ctl_d.loc_v = 1'b0;
        end
        if (accept && hot) begin
            ctl_d.loc_v    = 1'b1;
            ctl_d.loc_core = req_core;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done_valid  = (ctl_q.st == LC_RESP);
    assign done_core   = ctl_q.owner;
    assign local_valid = ctl_q.loc_v;
    assign local_core  = ctl_q.loc_core;

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> !done_valid); // R4
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_lock) && $stable(disp_core)); // R3
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !done_ready |=> done_valid && $stable(done_core)); // R5
    AST_LOCAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        local_valid && !local_ready |=> local_valid && $stable(local_core)); // R8
endmodule

// File: tb/cs_request_buffer_tb.sv
module cs_request_buffer_tb_top;
    localparam int CORE_W = 5;
    localparam int LOCK_W = 32;
    localparam int PC_W   = 32;
    localparam int SP_W   = 32;
    localparam int DEPTH  = 8;
    localparam int IDX_W  = 3;
    localparam int CNT_W  = 3;
    localparam int THRESH = 4;
    localparam int N_CNT  = 1 << IDX_W;
    localparam int C_MAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, disp_ready = 1'b0, ret_valid = 1'b0;
    logic done_ready = 1'b0, local_ready = 1'b0;
    logic [LOCK_W-1:0] req_lock = '0;
    logic [PC_W-1:0]   req_pc = '0;
    logic [SP_W-1:0]   req_sp = '0;
    logic [CORE_W-1:0] req_core = '0;
    logic req_ready, disp_valid, done_valid, local_valid;
    logic [LOCK_W-1:0] disp_lock;
    logic [PC_W-1:0]   disp_pc;
    logic [SP_W-1:0]   disp_sp;
    logic [CORE_W-1:0] disp_core, done_core, local_core;

    always #2 clk = ~clk;

    cs_request_buffer #(
        .CORE_W(CORE_W), .LOCK_W(LOCK_W), .PC_W(PC_W), .SP_W(SP_W),
        .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .THRESH(THRESH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_lock(req_lock),
        .req_pc(req_pc), .req_sp(req_sp), .req_core(req_core),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_lock(disp_lock),
        .disp_pc(disp_pc), .disp_sp(disp_sp), .disp_core(disp_core),
        .ret_valid(ret_valid), .done_valid(done_valid), .done_ready(done_ready),
        .done_core(done_core), .local_valid(local_valid), .local_ready(local_ready),
        .local_core(local_core)
    );

    typedef struct packed {
        logic [LOCK_W-1:0] lock;
        logic [PC_W-1:0]   pc;
        logic [SP_W-1:0]   sp;
        logic [CORE_W-1:0] core;
    } ent_t;

    ent_t mq[$];
    int   mst = 0;
    logic [CORE_W-1:0] mown = '0;
    logic [CORE_W-1:0] mloc_core = '0;
    bit   mloc_v = 1'b0;
    int   mcnt[N_CNT];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   running = 1'b0;
    bit   finished = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference, advanced at each rising edge from the inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mst = 0;
            mloc_v = 1'b0;
            for (int i = 0; i < N_CNT; i++) mcnt[i] = 0;
        end else begin
            bit acc, hot, conf, pop, alone;
            int ii, di;
            ent_t e;
            acc = req_valid && (mq.size() < DEPTH) && !mloc_v;
            ii  = int'(req_lock[IDX_W-1:0]);
            hot = (mcnt[ii] >= THRESH);
            conf = 1'b0;
            for (int k = 0; k < mq.size(); k++) if (mq[k].lock != req_lock) conf = 1'b1;
            pop = (mst == 0) && (mq.size() > 0) && disp_ready;
            alone = 1'b1;
            di = 0;
            if (mq.size() > 0) begin
                di = int'(mq[0].lock[IDX_W-1:0]);
                for (int k = 1; k < mq.size(); k++) if (mq[k].lock != mq[0].lock) alone = 1'b0;
            end
            // R6 / R7 counter rules
            if (acc && conf && !(pop && alone && di == ii)) begin
                if (mcnt[ii] < C_MAX) mcnt[ii]++;
            end
            if (pop && alone && !(acc && conf && di == ii)) begin
                if (mcnt[di] > 0) mcnt[di]--;
            end
            if (mloc_v && local_ready) mloc_v = 1'b0;
            if (acc && hot) begin
                mloc_v = 1'b1;
                mloc_core = req_core;
            end
            case (mst)
                0: if (pop) begin
                    mown = mq[0].core;
                    mst = 1;
                    void'(mq.pop_front());
                end
                1: if (ret_valid) mst = 2;
                default: if (done_ready) mst = 0;
            endcase
            if (acc && !hot) begin
                e.lock = req_lock; e.pc = req_pc; e.sp = req_sp; e.core = req_core;
                mq.push_back(e);
            end
        end
    end

    // Compare every cycle, well after the inputs change at the falling edge.
    always @(negedge clk) begin
        #1;
        if (running && rst_n) begin
            bit exp_disp;
            exp_disp = (mst == 0) && (mq.size() > 0);
            chk("R2 req_ready", 64'(req_ready), 64'((mq.size() < DEPTH) && !mloc_v));
            chk("R4 disp_valid", 64'(disp_valid), 64'(exp_disp));
            if (exp_disp) begin
                chk("R3 disp_lock", 64'(disp_lock), 64'(mq[0].lock));
                chk("R3 disp_pc", 64'(disp_pc), 64'(mq[0].pc));
                chk("R3 disp_sp", 64'(disp_sp), 64'(mq[0].sp));
                chk("R3 disp_core", 64'(disp_core), 64'(mq[0].core));
            end
            chk("R5 done_valid", 64'(done_valid), 64'(mst == 2));
            if (mst == 2) chk("R5 done_core", 64'(done_core), 64'(mown));
            chk("R8 local_valid (counters R6 R7)", 64'(local_valid), 64'(mloc_v));
            if (mloc_v) chk("R8 local_core", 64'(local_core), 64'(mloc_core));
        end
    end

    function automatic logic [LOCK_W-1:0] pick_lock(input int phase);
        if (phase == 2) return ((($urandom % 2) == 0) ? 32'h45 : 32'h45);
        case ($urandom % 5)
            0: return 32'h10;
            1: return 32'h18;
            2: return 32'h21;
            3: return 32'h29;
            default: return 32'h45;
        endcase
    endfunction

    function automatic logic pct(input int p);
        return (($urandom % 100) < p);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 disp_valid", 64'(disp_valid), 64'd0);
        chk("R1 done_valid", 64'(done_valid), 64'd0);
        chk("R1 local_valid", 64'(local_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            int ph;
            int p_req, p_disp, p_ret, p_done, p_loc;
            ph = (cyc < 400) ? 0 : (cyc < 1200) ? 1 : (cyc < 1800) ? 2 : 3;
            case (ph)
                0: begin p_req = 70; p_disp = 15; p_ret = 30; p_done = 60; p_loc = 70; end
                1: begin p_req = 50; p_disp = 80; p_ret = 80; p_done = 80; p_loc = 80; end
                2: begin p_req = 40; p_disp = 90; p_ret = 90; p_done = 90; p_loc = 90; end
                default: begin p_req = 60; p_disp = 50; p_ret = 50; p_done = 50; p_loc = 50; end
            endcase
            req_valid   = pct(p_req);
            req_lock    = pick_lock(ph);
            req_pc      = $urandom;
            req_sp      = $urandom;
            req_core    = CORE_W'($urandom % 28);
            disp_ready  = pct(p_disp);
            ret_valid   = pct(p_ret);
            done_ready  = pct(p_done);
            local_ready = pct(p_loc);
            @(negedge clk);
        end
        running = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule